// File: doc/BRIEF.md
# Interlace-Capable Display Timing Generator

This block produces the scan timing for one display pipe. It runs on the pixel clock and is set up through a small word-wide register port. Horizontal and vertical timing are each given as four segment lengths. From these the block forms active-high horizontal and vertical sync, a data-enable toward the output side and a field flag. Toward the upstream pixel source it drives a per-pixel request strobe and a one-cycle frame-start pulse.

Scan is either progressive or interlaced. In interlaced mode, fields alternate between two vertical timing sets. Software programs the even set with a back porch one line shorter than the odd set and with half the frame's visible height as the active line count. Frames either repeat until software withdraws the video-enable bit, or run once. The enable readback stays high until the running frame or field has ended, so software can poll it for a clean stop. The block raises a maskable interrupt when the vertical front porch begins. It also issues a pulse that resets the downstream pixel FIFO.

Top module: `vidTimingGen`

Register map (word address: content). Segment fields sit in bits [SEG_W-1:0] (low field) and [16+SEG_W-1:16] (high field).
- 0 control: bit0 pipe enable, bit1 FIFO clear (write-only, reads 0), bit2 line-aligned start
- 1 scan: bit0 video enable, bit1 continuous, bit2 interlace
- 2: low = horizontal back porch, high = horizontal sync
- 3: low = horizontal front porch, high = horizontal active
- 4 / 5: same layout as 2 / 3 for the vertical odd set (in lines)
- 6 / 7: same layout as 2 / 3 for the vertical even set
- 8: bit0 interrupt enable
- 9: bit0 front-porch status, write 1 to clear

## Requirements
- R1: After reset every output is low, and the scan, status and timing registers read 0.
- R2: A line is the segments sync, back porch, active and front porch in that order. Each segment lasts its programmed number of pixel clocks, and a programmed 0 counts as 1. hsync is high during the sync segment.
- R3: A frame is built from lines in the same order (sync, back porch, active, front porch), using the vertical lengths of the current field's set. vsync is high during the sync lines.
- R4: pixReq is high on exactly the cycles that are inside both the horizontal and the vertical active segment. de, hsync, vsync and field show the same timing one cycle later than pixReq does.
- R5: vStart is a one-cycle pulse in the first cycle of every frame or field, on the same timebase as pixReq.
- R6: With interlace set, the first field after a start uses the odd set (field output 0), and following fields alternate with the even set (field output 1). Without interlace, field stays 0.
- R7: With continuous clear, a start produces exactly one frame, and the video-enable readback then returns 0.
- R8: Clearing video enable lets the current frame finish. The readback bit stays 1 until the first cycle after that frame's last cycle, and no further vStart occurs.
- R9: The status bit (address 9, bit0) sets in the first cycle of the first vertical front-porch line. irq is status AND enable. Writing 1 clears status, and writing 0 has no effect.
- R10: A control write with bit0 and bit1 both set gives a one-cycle fifoRst pulse in the cycle after the write. A write with only bit1 set gives no pulse, and bit1 reads back 0.
- R11: With line-aligned start clear, a frame begins two cycles after the video-enable write edge. With it set, the frame begins at the next line boundary of the line counter, which free-runs from the pipe-enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word address |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data (combinational) |
| pixReq | output | 1 | Pixel request to the upstream source |
| vStart | output | 1 | Frame/field start pulse to the upstream source |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Active-video enable |
| field | output | 1 | Field flag, 1 for the even field |
| fifoRst | output | 1 | Pixel FIFO reset pulse |
| irq | output | 1 | Front-porch interrupt |

## Verification
The bench builds the block with SEG_W=6. This keeps a frame down to a few dozen cycles, so every cycle of two whole progressive frames and two whole odd/even field pairs is compared against positions worked out by division and remainder. A horizontal front porch programmed as 0 and an even-field back porch one line shorter both appear inside those sweeps. The short frames also make it cheap to time the stop readback, the single-shot end and the line-aligned start to the exact cycle.

// File: rtl/vtg_pkg.sv
`timescale 1ns/1ps
package vtg_pkg;
  // Segment order within a line and within a frame.
  typedef enum logic [1:0] {
    SEG_SYNC  = 2'd0,
    SEG_BACK  = 2'd1,
    SEG_ACT   = 2'd2,
    SEG_FRONT = 2'd3
  } seg_e;

  // Control -> datapath strobes.
  typedef struct packed {
    logic load;      // begin a frame/field at the next edge
    logic loadEven;  // that frame uses the even vertical set
    logic curEven;   // current frame uses the even vertical set
    logic running;   // a frame is in progress
  } vtg_strobe_t;

  // Datapath -> control events.
  typedef struct packed {
    logic lineEnd;   // last cycle of a line
    logic frameEnd;  // last cycle of a running frame
    logic fpEnter;   // last cycle before vertical front porch
  } vtg_event_t;
endpackage

// File: rtl/vtgCtrl.sv
`timescale 1ns/1ps
module vtgCtrl
  import vtg_pkg::*;
#(
  parameter int SEG_W  = 12,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWe,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [DATA_W-1:0]        regWdata,
  output logic [DATA_W-1:0]        regRdata,
  input  vtg_event_t               evt,
  output vtg_strobe_t              strb,
  output logic                     pipeEn,
  output logic [3:0][SEG_W-1:0]    hLen,
  output logic [3:0][SEG_W-1:0]    vLenOdd,
  output logic [3:0][SEG_W-1:0]    vLenEven,
  output logic                     fifoRst,
  output logic                     irq
);
  localparam int HI = 16;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SCAN = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_HA   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_HB   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_VOA  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_VOB  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_VEA  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_VEB  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_IST  = ADDR_W'(9);

  logic lineAlign, runReq, contMode, ilace, irqEn, irqStat;
  logic running, fieldReg;
  logic startNow, contNow, stopNow;
  logic [SEG_W-1:0] loField, hiField;

  wire unusedWdata = &{1'b0, regWdata};

  assign loField = regWdata[SEG_W-1:0];
  assign hiField = regWdata[HI +: SEG_W];

  function automatic logic wrAt(input logic [ADDR_W-1:0] a);
    return regWe && (regAddr == a);
  endfunction

  // Frame sequencing
  assign startNow = !running && runReq && pipeEn && (!lineAlign || evt.lineEnd);
  assign contNow  = running && evt.frameEnd && runReq && contMode && pipeEn;
  assign stopNow  = running && (!pipeEn || (evt.frameEnd && !contNow));

  assign strb.load     = startNow || contNow;
  assign strb.loadEven = contNow && ilace && !fieldReg;
  assign strb.curEven  = ilace && fieldReg;
  assign strb.running  = running;

  assign irq = irqStat && irqEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeEn <= 1'b0; lineAlign <= 1'b0; runReq <= 1'b0; contMode <= 1'b0;
      ilace <= 1'b0; irqEn <= 1'b0; irqStat <= 1'b0; running <= 1'b0;
      fieldReg <= 1'b0; fifoRst <= 1'b0;
      hLen <= '0; vLenOdd <= '0; vLenEven <= '0;
    end else begin
      fifoRst <= wrAt(A_CTRL) && regWdata[0] && regWdata[1];
      if (wrAt(A_CTRL)) begin
        pipeEn    <= regWdata[0];
        lineAlign <= regWdata[2];
      end
      if (wrAt(A_SCAN)) begin
        runReq   <= regWdata[0];
        contMode <= regWdata[1];
        ilace    <= regWdata[2];
      end else if (running && evt.frameEnd && !contMode) begin
        runReq <= 1'b0;
      end
      if (wrAt(A_HA))  begin hLen[SEG_BACK]      <= loField; hLen[SEG_SYNC]      <= hiField; end
      if (wrAt(A_HB))  begin hLen[SEG_FRONT]     <= loField; hLen[SEG_ACT]       <= hiField; end
      if (wrAt(A_VOA)) begin vLenOdd[SEG_BACK]   <= loField; vLenOdd[SEG_SYNC]   <= hiField; end
      if (wrAt(A_VOB)) begin vLenOdd[SEG_FRONT]  <= loField; vLenOdd[SEG_ACT]    <= hiField; end
      if (wrAt(A_VEA)) begin vLenEven[SEG_BACK]  <= loField; vLenEven[SEG_SYNC]  <= hiField; end
      if (wrAt(A_VEB)) begin vLenEven[SEG_FRONT] <= loField; vLenEven[SEG_ACT]   <= hiField; end
      if (wrAt(A_IEN)) irqEn <= regWdata[0];
      if (evt.fpEnter)                        irqStat <= 1'b1;
      else if (wrAt(A_IST) && regWdata[0])    irqStat <= 1'b0;
      if (startNow) begin
        running  <= 1'b1;
        fieldReg <= 1'b0;
      end else if (contNow) begin
        fieldReg <= ilace && !fieldReg;
      end else if (stopNow) begin
        running  <= 1'b0;
        fieldReg <= 1'b0;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      A_CTRL: begin regRdata[0] = pipeEn; regRdata[2] = lineAlign; end
      A_SCAN: begin regRdata[0] = runReq || running; regRdata[1] = contMode; regRdata[2] = ilace; end
      A_HA:   begin regRdata[SEG_W-1:0] = hLen[SEG_BACK];      regRdata[HI +: SEG_W] = hLen[SEG_SYNC];     end
      A_HB:   begin regRdata[SEG_W-1:0] = hLen[SEG_FRONT];     regRdata[HI +: SEG_W] = hLen[SEG_ACT];      end
      A_VOA:  begin regRdata[SEG_W-1:0] = vLenOdd[SEG_BACK];   regRdata[HI +: SEG_W] = vLenOdd[SEG_SYNC];  end
      A_VOB:  begin regRdata[SEG_W-1:0] = vLenOdd[SEG_FRONT];  regRdata[HI +: SEG_W] = vLenOdd[SEG_ACT];   end
      A_VEA:  begin regRdata[SEG_W-1:0] = vLenEven[SEG_BACK];  regRdata[HI +: SEG_W] = vLenEven[SEG_SYNC]; end
      A_VEB:  begin regRdata[SEG_W-1:0] = vLenEven[SEG_FRONT]; regRdata[HI +: SEG_W] = vLenEven[SEG_ACT];  end
      A_IEN:  regRdata[0] = irqEn;
      A_IST:  regRdata[0] = irqStat;
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/vtgDatapath.sv
`timescale 1ns/1ps
module vtgDatapath
  import vtg_pkg::*;
#(
  parameter int SEG_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pipeEn,
  input  vtg_strobe_t           strb,
  input  logic [3:0][SEG_W-1:0] hLen,
  input  logic [3:0][SEG_W-1:0] vLenOdd,
  input  logic [3:0][SEG_W-1:0] vLenEven,
  output vtg_event_t            evt,
  output logic                  pixReq,
  output logic                  vStart,
  output logic                  hsync,
  output logic                  vsync,
  output logic                  de,
  output logic                  field
);
  localparam logic [SEG_W-1:0] ONE = SEG_W'(1);

  seg_e hSeg, vSeg;
  logic [SEG_W-1:0] hCnt, vCnt;
  logic [3:0][SEG_W-1:0] vCur, vNew;
  logic hLast, vLast, lineEnd;
  seg_e hNext, vNext;

  function automatic logic [SEG_W-1:0] effLen(input logic [SEG_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  assign vCur  = strb.curEven  ? vLenEven : vLenOdd;
  assign vNew  = strb.loadEven ? vLenEven : vLenOdd;
  assign hLast = (hCnt <= ONE);
  assign vLast = (vCnt <= ONE);
  assign hNext = seg_e'(hSeg + 2'd1);
  assign vNext = seg_e'(vSeg + 2'd1);

  assign lineEnd      = pipeEn && (hSeg == SEG_FRONT) && hLast;
  assign evt.lineEnd  = lineEnd;
  assign evt.frameEnd = strb.running && lineEnd && (vSeg == SEG_FRONT) && vLast;
  assign evt.fpEnter  = strb.running && lineEnd && (vSeg == SEG_ACT) && vLast;

  // Horizontal segment counter: free-runs while the pipe is enabled.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hSeg <= SEG_SYNC;
      hCnt <= '0;
    end else if (!pipeEn || strb.load) begin
      hSeg <= SEG_SYNC;
      hCnt <= effLen(hLen[SEG_SYNC]);
    end else if (hLast) begin
      hSeg <= hNext;
      hCnt <= effLen(hLen[hNext]);
    end else begin
      hCnt <= hCnt - ONE;
    end
  end

  // Vertical segment counter: advances once per line of a running frame.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vSeg <= SEG_SYNC;
      vCnt <= '0;
    end else if (strb.load) begin
      vSeg <= SEG_SYNC;
      vCnt <= effLen(vNew[SEG_SYNC]);
    end else if (strb.running && lineEnd) begin
      if (vLast) begin
        vSeg <= vNext;
        vCnt <= effLen(vCur[vNext]);
      end else begin
        vCnt <= vCnt - ONE;
      end
    end
  end

  assign pixReq = strb.running && (hSeg == SEG_ACT) && (vSeg == SEG_ACT);

  // Output stage: one cycle behind the request timebase.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vStart <= 1'b0; hsync <= 1'b0; vsync <= 1'b0; de <= 1'b0; field <= 1'b0;
    end else begin
      vStart <= strb.load;
      hsync  <= strb.running && (hSeg == SEG_SYNC);
      vsync  <= strb.running && (vSeg == SEG_SYNC);
      de     <= pixReq;
      field  <= strb.running && strb.curEven;
    end
  end
endmodule

// File: rtl/vidTimingGen.sv
`timescale 1ns/1ps
module vidTimingGen
  import vtg_pkg::*;
#(
  parameter int SEG_W  = 12,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              pixReq,
  output logic              vStart,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              field,
  output logic              fifoRst,
  output logic              irq
);
  vtg_strobe_t           strb;
  vtg_event_t            evt;
  logic                  pipeEn;
  logic [3:0][SEG_W-1:0] hLen, vLenOdd, vLenEven;

  vtgCtrl #(.SEG_W(SEG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .evt(evt), .strb(strb), .pipeEn(pipeEn), .hLen(hLen),
    .vLenOdd(vLenOdd), .vLenEven(vLenEven), .fifoRst(fifoRst), .irq(irq)
  );

  vtgDatapath #(.SEG_W(SEG_W)) u_dp (
    .clk(clk), .rstN(rstN), .pipeEn(pipeEn), .strb(strb), .hLen(hLen),
    .vLenOdd(vLenOdd), .vLenEven(vLenEven), .evt(evt), .pixReq(pixReq),
    .vStart(vStart), .hsync(hsync), .vsync(vsync), .de(de), .field(field)
  );
endmodule

// File: rtl/vtgChecker.sv
`timescale 1ns/1ps
module vtgChecker (
  input logic clk,
  input logic rstN,
  input logic pixReq,
  input logic vStart,
  input logic hsync,
  input logic vsync,
  input logic de
);
  // R4: data-enable trails the request timebase by one cycle
  a_r4_de_lags_req: assert property (@(posedge clk) disable iff (!rstN)
    de == $past(pixReq));

  // R5: frame start is a single-cycle pulse
  a_r5_vstart_single: assert property (@(posedge clk) disable iff (!rstN)
    vStart |=> !vStart);

  // R5: the cycle after a frame start shows both syncs on the output side
  a_r5_vstart_syncs: assert property (@(posedge clk) disable iff (!rstN)
    vStart |=> (hsync && vsync));

  // R2: sync and active video never overlap horizontally
  a_r2_hsync_no_de: assert property (@(posedge clk) disable iff (!rstN)
    !(hsync && de));

  // R3: sync lines carry no active video
  a_r3_vsync_no_de: assert property (@(posedge clk) disable iff (!rstN)
    !(vsync && de));
endmodule

bind vidTimingGen vtgChecker u_vtgChecker (
  .clk(clk), .rstN(rstN), .pixReq(pixReq), .vStart(vStart),
  .hsync(hsync), .vsync(vsync), .de(de)
);

// File: tb/test_vidTimingGen.sv
`timescale 1ns/1ps
module test_vidTimingGen;
  localparam int SEG_W = 6, ADDR_W = 4, DATA_W = 32;
  localparam int HS = 2, HB = 1, HA = 3, HFP = 0, HF = 1;  // HFP programmed 0, counts as 1
  localparam int L  = HS + HB + HA + HF;
  localparam int VS = 1, VBO = 2, VBE = 1, VA = 2, VF = 1;
  localparam int FO = (VS + VBO + VA + VF) * L;
  localparam int FE = (VS + VBE + VA + VF) * L;
  localparam int FPK = (VS + VBO + VA) * L;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWe = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic pixReq, vStart, hsync, vsync, de, field, fifoRst, irq;

  always #5 clk = ~clk;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  vidTimingGen #(.SEG_W(SEG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_vidTimingGen (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .pixReq(pixReq), .vStart(vStart), .hsync(hsync),
    .vsync(vsync), .de(de), .field(field), .fifoRst(fifoRst), .irq(irq)
  );

  int nChecks = 0, nErr = 0, lastCyc = 0, sweepEnd = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; lastCyc = cyc;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  function automatic void expAt(input int k, input bit il, output bit pr, output bit hs,
                                output bit vs, output bit fe, output bit first);
    int off, vb, x, y;
    if (il) begin
      off = k % (FO + FE); fe = (off >= FO);
      if (fe) off = off - FO;
    end else begin
      off = k % FO; fe = 1'b0;
    end
    vb = fe ? VBE : VBO;
    x = off % L; y = off / L;
    hs = (x < HS); vs = (y < VS);
    pr = (x >= HS + HB) && (x < HS + HB + HA) && (y >= VS + vb) && (y < VS + vb + VA);
    first = (off == 0);
  endfunction

  task automatic waitStart();
    int guard = 0;
    while (vStart !== 1'b1 && guard < 300) begin @(negedge clk); guard++; end
    chk("R5 frame start seen", vStart, 1);
  endtask

  task automatic sweep(input bit il, input int n, input bit doIrq);
    waitStart();
    for (int k = 0; k < n; k++) begin
      bit pr, hs, vs, fe, first, ppr, phs, pvs, pfe, pfirst;
      expAt(k, il, pr, hs, vs, fe, first);
      chk("R4 pixReq", pixReq, pr);
      chk("R5 vStart", vStart, first);
      if (k > 0) begin
        expAt(k - 1, il, ppr, phs, pvs, pfe, pfirst);
        chk("R2 hsync", hsync, phs);
        chk("R3 vsync", vsync, pvs);
        chk("R4 de", de, ppr);
        chk("R6 field", field, pfe);
      end
      if (doIrq) chk("R9 irq at front porch", irq, (k >= FPK));
      @(negedge clk);
    end
    sweepEnd = cyc;
  endtask

  initial begin
    #(200000 * 10);
    nChecks++; nErr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] d;
    int c, w, t, s, fall, starts, expT;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 pixReq", pixReq, 0); chk("R1 hsync", hsync, 0); chk("R1 vsync", vsync, 0);
    chk("R1 de", de, 0); chk("R1 irq", irq, 0); chk("R1 fifoRst", fifoRst, 0);
    rstN = 1'b1;
    @(negedge clk);
    rd(4'd1, d); chk("R1 scan reg", d, 0);
    rd(4'd9, d); chk("R1 status reg", d, 0);
    rd(4'd2, d); chk("R1 timing reg", d, 0);

    wr(4'd2, HB | (HS << 16));
    wr(4'd3, HFP | (HA << 16));
    wr(4'd4, VBO | (VS << 16));
    wr(4'd5, VF | (VA << 16));
    wr(4'd6, VBE | (VS << 16));
    wr(4'd7, VF | (VA << 16));
    rd(4'd3, d); chk("R2 timing readback", d, HFP | (HA << 16));
    wr(4'd8, 1);
    wr(4'd0, 1);
    wr(4'd9, 1);

    // R11: immediate start, progressive continuous sweep (R2 R3 R4 R5 R9)
    wr(4'd1, 3); w = lastCyc;
    chk("R11 no start yet", vStart, 0);
    @(negedge clk);
    chk("R11 start two cycles after write", vStart, 1);
    chk("R11 start cycle", cyc, w + 1);
    sweep(1'b0, 2 * FO, 1'b1);
    s = sweepEnd;
    chk("R5 third frame start", vStart, 1);

    // R8: stop at frame end
    wr(4'd1, 2);
    rd(4'd1, d); chk("R8 readback held mid frame", d[0], 1);
    fall = -1; starts = 0;
    for (int i = 0; i < 2 * FO; i++) begin
      @(negedge clk);
      if (vStart === 1'b1) starts++;
      if (regRdata[0] === 1'b0 && fall < 0) fall = cyc;
    end
    chk("R8 no further frame", starts, 0);
    chk("R8 readback falls after frame", fall, s + FO);
    chk("R8 output idle", pixReq, 0);

    // R9: interrupt status handling
    chk("R9 irq pending", irq, 1);
    wr(4'd9, 0); chk("R9 write 0 ignored", irq, 1);
    wr(4'd8, 0); chk("R9 masked", irq, 0);
    rd(4'd9, d); chk("R9 status still set", d[0], 1);
    wr(4'd9, 1);
    rd(4'd9, d); chk("R9 cleared by write 1", d[0], 0);
    wr(4'd8, 1); chk("R9 irq low after clear", irq, 0);

    // R6: interlaced sweep over two field pairs
    wr(4'd1, 7);
    sweep(1'b1, 2 * (FO + FE), 1'b0);
    wr(4'd1, 0);
    repeat (FO + FE + 5) @(negedge clk);
    chk("R6 field low when stopped", field, 0);
    rd(4'd1, d); chk("R6 readback after stop", d[0], 0);

    // R7: single shot
    wr(4'd1, 1);
    waitStart();
    starts = 0;
    for (int i = 0; i < 2 * FO; i++) begin
      @(negedge clk);
      if (vStart === 1'b1) starts++;
      if (i == FO / 2) begin rd(4'd1, d); chk("R7 readback during frame", d[0], 1); end
    end
    chk("R7 exactly one frame", starts, 0);
    rd(4'd1, d); chk("R7 readback after frame", d[0], 0);

    // R11: line-aligned start
    wr(4'd0, 0);
    wr(4'd0, 5); c = lastCyc;
    repeat (3) @(negedge clk);
    wr(4'd1, 1); w = lastCyc;
    waitStart(); t = cyc;
    expT = c + ((w + 1 - c + L - 1) / L) * L;
    chk("R11 aligned start cycle", t, expT);
    sweep(1'b0, FO, 1'b0);

    // R10: FIFO reset pulse
    wr(4'd0, 3);
    chk("R10 pulse after write", fifoRst, 1);
    @(negedge clk);
    chk("R10 pulse one cycle", fifoRst, 0);
    rd(4'd0, d); chk("R10 clear bit reads 0", d, 1);
    wr(4'd0, 2);
    chk("R10 no pulse without enable", fifoRst, 0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule